// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Fractional Stop Length

This block turns one parallel character at a time into an asynchronous serial frame on a single line. A frame is a low start bit, then 1 to 8 data bits with the least significant bit first, then an optional parity bit, then a high stop period. An external baud generator supplies a one-cycle enable `tick`. A programmable clock factor sets how many ticks make up one bit time.

The stop period is given in sixteenths of a bit. When the clock factor is 16, the stop period lasts exactly that many ticks. The next start bit can therefore begin partway through a bit time. With any other factor, the stop length is rounded up to whole bits.

The block can also hold the line low as a break for as long as a request input stays high. A full stop period follows when the request is released. Characters arrive through a valid/ready handshake. The configuration inputs are captured at the moment a character is accepted or a break begins.

Top module: `async_tx_frac`

## Requirements
- R1: After reset, `tx` is 1, `busy` is 0 and `in_ready` is 1. Whenever `busy` is 0, `tx` is 1.
- R2: A character is accepted on a clock edge where `in_valid` and `in_ready` are both 1. From that edge, `tx` sends a start bit of 0 lasting F ticks. It then sends `cfg_data_bits` data bits, least significant bit first, each lasting F ticks.
- R3: `cfg_parity` selects the parity bit with 0 = none, 1 = odd, 2 = even, 3 = mark (1) and 4 = space (0). Odd and even parity are computed over the enabled data bits only. The parity bit lasts F ticks and follows the last data bit.
- R4: The stop period is high. With `cfg_factor` = 16 it lasts exactly `cfg_stop` ticks, where `cfg_stop` is 1 to 32. With any other factor it lasts ceil(`cfg_stop`/16) bit times of F ticks each.
- R5: F is `cfg_factor`, from 1 to 64. Only ticks seen at clock edges after the accepting edge are counted, and `tx` changes only after a counted tick.
- R6: `in_ready` is 1 only when the block is idle and `break_req` is 0. `busy` is 1 from the accepting edge until the edge of the final stop tick, and `in_ready` returns to 1 on that same edge.
- R7: The data and configuration are captured at the accepting edge. Changes to `in_data` or the `cfg_*` inputs during a frame have no effect on that frame.
- R8: If `break_req` is 1 while the block is idle, `tx` goes to 0 and `busy` to 1 from the next edge, and both stay there while the request is held. A request raised during a frame waits until that frame's stop period has ended. `in_valid` is ignored during a break.
- R9: After `break_req` falls, `tx` is 1 and `busy` stays 1 for one stop period. That period follows R4, using the configuration captured when the break began. The block is idle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Baud enable, one tick per cycle it is high |
| cfg_factor | input | 7 | Ticks per bit, 1 to 64 |
| cfg_data_bits | input | 4 | Data bits per character, 1 to 8 |
| cfg_parity | input | 3 | Parity mode code (see R3) |
| cfg_stop | input | 6 | Stop length in sixteenths of a bit, 1 to 32 |
| break_req | input | 1 | Hold line low as a break while high |
| in_valid | input | 1 | Character offered |
| in_data | input | 8 | Character to send |
| in_ready | output | 1 | Block can accept a character |
| busy | output | 1 | Frame, break or post-break stop in progress |
| tx | output | 1 | Serial line output |

## Verification
The bench builds the block with its default parameters: 8-bit data, a clock factor of up to 64 and a 6-bit stop field. It drives a tick on every second clock. With these values, the table's clock factors of 1, 4, 8 and 16 exercise both stop paths: the exact sixteenth-bit count at factor 16 and the round-up to whole bits elsewhere. The stop values tested include the extremes of 1/16 bit and 2 bits. Each frame is compared tick by tick against a frame built from the requirements. This covers every parity mode and the shortest and longest characters, and also the break sequences both from idle and from a request held over a running frame.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;

    typedef enum logic [2:0] {
        PAR_NONE  = 3'd0,
        PAR_ODD   = 3'd1,
        PAR_EVEN  = 3'd2,
        PAR_MARK  = 3'd3,
        PAR_SPACE = 3'd4
    } par_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_BREAK,
        ST_BRK_STOP
    } tx_state_e;

    // Clock factor at which stop lengths are counted in raw ticks
    localparam int unsigned FINE_FACTOR = 16;

    function automatic logic parity_present(par_mode_e m);
        return (m == PAR_ODD) || (m == PAR_EVEN) ||
               (m == PAR_MARK) || (m == PAR_SPACE);
    endfunction

    // ones_xor is the XOR of the enabled data bits
    function automatic logic parity_value(par_mode_e m, logic ones_xor);
        case (m)
            PAR_ODD:  return ~ones_xor;
            PAR_EVEN: return ones_xor;
            PAR_MARK: return 1'b1;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/async_tx_timer.sv
module async_tx_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             restart,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    // done marks the tick that closes the current interval
    assign done = tick && !restart && (cnt == limit - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst || restart || done) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/async_tx_shifter.sv
module async_tx_shifter
    import async_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NB_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              shift,
    input  logic [DATA_W-1:0] data,
    input  logic [NB_W-1:0]   nbits,
    input  par_mode_e         mode,
    output logic              line_bit,
    output logic              par_bit
);
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] sh;
    logic              par_q;

    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        assign mask[i] = (NB_W'(i) < nbits);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh    <= '0;
            par_q <= 1'b0;
        end else if (load) begin
            sh    <= data;
            par_q <= parity_value(mode, ^(data & mask));
        end else if (shift) begin
            sh    <= sh >> 1;
        end
    end

    assign line_bit = sh[0];
    assign par_bit  = par_q;
endmodule

// File: rtl/async_tx_frac.sv
module async_tx_frac
    import async_tx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int MAX_FACTOR = 64,
    parameter int STOP_W     = 6,
    localparam int FACT_W    = $clog2(MAX_FACTOR + 1),
    localparam int NB_W      = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [FACT_W-1:0] cfg_factor,
    input  logic [NB_W-1:0]   cfg_data_bits,
    input  logic [2:0]        cfg_parity,
    input  logic [STOP_W-1:0] cfg_stop,
    input  logic              break_req,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              busy,
    output logic              tx
);
    localparam int CNT_W   = $clog2(2 * MAX_FACTOR + 1);
    localparam int WHOLE_W = STOP_W - 3;

    tx_state_e         state;
    logic [FACT_W-1:0] factor_q;
    logic [NB_W-1:0]   nbits_q;
    par_mode_e         par_q;
    logic [STOP_W-1:0] stop_q;
    logic [NB_W-1:0]   bit_cnt;

    logic              idle;
    logic              accept;
    logic              restart;
    logic              done;
    logic [CNT_W-1:0]  limit;
    logic [CNT_W-1:0]  stop_ticks;
    logic [STOP_W:0]   stop_up;
    logic [WHOLE_W-1:0] stop_whole;
    logic              line_bit;
    logic              par_bit;
    logic              shift;

    assign idle     = (state == ST_IDLE);
    assign in_ready = idle && !break_req;
    assign accept   = in_valid && in_ready;
    assign busy     = !idle;
    assign restart  = idle || (state == ST_BREAK);
    assign shift    = (state == ST_DATA) && done;

    // Stop length: raw sixteenths at the fine factor, whole bits otherwise
    assign stop_up    = {1'b0, stop_q} + (STOP_W + 1)'(15);
    assign stop_whole = stop_up[STOP_W:4];

    always_comb begin
        if (factor_q == FACT_W'(FINE_FACTOR)) begin
            stop_ticks = CNT_W'(stop_q);
        end else begin
            stop_ticks = CNT_W'(stop_whole) * CNT_W'(factor_q);
        end
    end

    always_comb begin
        if (state == ST_STOP || state == ST_BRK_STOP) begin
            limit = stop_ticks;
        end else begin
            limit = CNT_W'(factor_q);
        end
    end

    async_tx_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .restart (restart),
        .limit   (limit),
        .done    (done)
    );

    async_tx_shifter #(.DATA_W(DATA_W), .NB_W(NB_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .shift    (shift),
        .data     (in_data),
        .nbits    (cfg_data_bits),
        .mode     (par_mode_e'(cfg_parity)),
        .line_bit (line_bit),
        .par_bit  (par_bit)
    );

    // Configuration tracks the inputs while idle and freezes on leaving idle
    always_ff @(posedge clk) begin
        if (rst) begin
            factor_q <= FACT_W'(FINE_FACTOR);
            nbits_q  <= NB_W'(DATA_W);
            par_q    <= PAR_NONE;
            stop_q   <= STOP_W'(16);
        end else if (idle) begin
            factor_q <= cfg_factor;
            nbits_q  <= cfg_data_bits;
            par_q    <= par_mode_e'(cfg_parity);
            stop_q   <= cfg_stop;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    bit_cnt <= '0;
                    if (break_req) begin
                        state <= ST_BREAK;
                    end else if (in_valid) begin
                        state <= ST_START;
                    end
                end
                ST_START: begin
                    if (done) begin
                        state <= ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (done) begin
                        if (bit_cnt == nbits_q - NB_W'(1)) begin
                            state <= parity_present(par_q) ? ST_PARITY : ST_STOP;
                        end else begin
                            bit_cnt <= bit_cnt + NB_W'(1);
                        end
                    end
                end
                ST_PARITY: begin
                    if (done) begin
                        state <= ST_STOP;
                    end
                end
                ST_STOP: begin
                    if (done) begin
                        state <= ST_IDLE;
                    end
                end
                ST_BREAK: begin
                    if (!break_req) begin
                        state <= ST_BRK_STOP;
                    end
                end
                ST_BRK_STOP: begin
                    if (done) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        case (state)
            ST_START:  tx = 1'b0;
            ST_DATA:   tx = line_bit;
            ST_PARITY: tx = par_bit;
            ST_BREAK:  tx = 1'b0;
            default:   tx = 1'b1;
        endcase
    end
endmodule

// File: rtl/async_tx_frac_chk.sv
module async_tx_frac_chk (
    input logic clk,
    input logic rst,
    input logic tick,
    input logic break_req,
    input logic in_valid,
    input logic in_ready,
    input logic busy,
    input logic tx
);
    // R1: line is high whenever nothing is in progress
    a_r1_idle_mark: assert property (@(posedge clk) disable iff (rst)
        !busy |-> tx);

    // R6: ready only when idle and no break is requested
    a_r6_ready_idle: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> (!busy && !break_req));

    // R2: an accepted character starts with a low start bit
    a_r2_start_low: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (busy && !tx));

    // R5: a frame or post-break stop only ends on a counted tick
    a_r5_end_on_tick: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(tick));

    // R8: a break requested while idle pulls the line low on the next edge
    a_r8_break_low: assert property (@(posedge clk) disable iff (rst)
        (!busy && break_req) |=> (busy && !tx));
endmodule

bind async_tx_frac async_tx_frac_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .break_req (break_req),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .busy      (busy),
    .tx        (tx)
);

// File: tb/async_tx_frac_test.sv
module async_tx_frac_test;

    typedef struct packed {
        logic [6:0] f;
        logic [3:0] nb;
        logic [2:0] par;
        logic [5:0] stop;
        logic [7:0] d;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{7'd16, 4'd8, 3'd0, 6'd16, 8'hA5},
        '{7'd16, 4'd7, 3'd1, 6'd24, 8'h3C},
        '{7'd16, 4'd8, 3'd2, 6'd1,  8'h81},
        '{7'd16, 4'd5, 3'd3, 6'd32, 8'h1F},
        '{7'd16, 4'd1, 3'd4, 6'd7,  8'h01},
        '{7'd1,  4'd8, 3'd2, 6'd16, 8'h5A},
        '{7'd4,  4'd6, 3'd1, 6'd20, 8'h2B},
        '{7'd16, 4'd8, 3'd1, 6'd31, 8'hFF},
        '{7'd8,  4'd3, 3'd0, 6'd1,  8'h06}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [6:0] cfg_factor = 7'd16;
    logic [3:0] cfg_data_bits = 4'd8;
    logic [2:0] cfg_parity = 3'd0;
    logic [5:0] cfg_stop = 6'd16;
    logic       break_req = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready;
    logic       busy;
    logic       tx;

    int errors = 0;
    int checks = 0;
    int tdiv = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    // Tick every second clock, updated just after the rising edge
    always @(posedge clk) begin
        tick <= (tdiv == 0);
        tdiv <= (tdiv == 1) ? 0 : tdiv + 1;
    end

    async_tx_frac uut (
        .clk           (clk),
        .rst           (rst),
        .tick          (tick),
        .cfg_factor    (cfg_factor),
        .cfg_data_bits (cfg_data_bits),
        .cfg_parity    (cfg_parity),
        .cfg_stop      (cfg_stop),
        .break_req     (break_req),
        .in_valid      (in_valid),
        .in_data       (in_data),
        .in_ready      (in_ready),
        .busy          (busy),
        .tx            (tx)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int stop_len(input int f, input int s);
        if (f == 16) return s;
        return ((s + 15) / 16) * f;
    endfunction

    function automatic bit has_par(input int p);
        return (p >= 1) && (p <= 4);
    endfunction

    function automatic logic exp_bit(input vec_t v, input int k);
        int seg;
        logic [7:0] m;
        seg = k / int'(v.f);
        m = v.d & 8'((1 << int'(v.nb)) - 1);
        if (seg == 0) return 1'b0;
        if (seg <= int'(v.nb)) return v.d[seg - 1];
        if (has_par(int'(v.par)) && seg == int'(v.nb) + 1) begin
            case (v.par)
                3'd1: return ~^m;
                3'd2: return ^m;
                3'd3: return 1'b1;
                default: return 1'b0;
            endcase
        end
        return 1'b1;
    endfunction

    // Wait for the next negedge at which tick is high
    task automatic next_tick();
        @(negedge clk);
        while (!tick) @(negedge clk);
    endtask

    // Samples a stop period of s ticks after a state-changing edge
    task automatic check_stop_only(input int s, input string tag);
        int bad = 0;
        for (int k = 0; k < s; k++) begin
            next_tick();
            if (tx !== 1'b1 || busy !== 1'b1) bad++;
        end
        check(bad == 0, {tag, " stop high with busy"}, bad, 0);
        @(negedge clk);
        check(busy === 1'b0 && tx === 1'b1, {tag, " idle after stop"}, int'(busy), 0);
    endtask

    task automatic send_frame(input vec_t v, input bit brk_mid);
        int f, nf, s, total, bad_d, bad_p, bad_s, bad_c;
        logic b;
        f = int'(v.f);
        nf = 1 + int'(v.nb) + (has_par(int'(v.par)) ? 1 : 0);
        s = stop_len(f, int'(v.stop));
        total = nf * f + s;
        bad_d = 0; bad_p = 0; bad_s = 0; bad_c = 0;
        @(negedge clk);
        cfg_factor = v.f; cfg_data_bits = v.nb; cfg_parity = v.par;
        cfg_stop = v.stop; in_data = v.d; in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        for (int k = 0; k < total; k++) begin
            next_tick();
            if (k == 0) begin
                // R7: disturb inputs once the frame is under way
                in_valid = 1'b0; in_data = ~v.d;
                cfg_factor = 7'd3; cfg_data_bits = 4'd2; cfg_parity = 3'd3;
                cfg_stop = 6'd5;
                if (brk_mid) break_req = 1'b1;
            end
            b = exp_bit(v, k);
            if (tx !== b) begin
                if (k >= nf * f) bad_s++;
                else if (k / f > int'(v.nb)) bad_p++;
                else bad_d++;
            end
            if (busy !== 1'b1 || in_ready !== 1'b0) bad_c++;
        end
        check(bad_d == 0, "R2 R5 R7 start and data bits", bad_d, 0);
        if (has_par(int'(v.par)))
            check(bad_p == 0, "R3 parity bit", bad_p, 0);
        check(bad_s == 0, "R4 stop period high", bad_s, 0);
        check(bad_c == 0, "R6 busy high and ready low in frame", bad_c, 0);
        @(negedge clk);
        check(busy === 1'b0 && tx === 1'b1, "R4 frame ends on last stop tick", int'(busy), 0);
        check(in_ready === !brk_mid, "R6 ready back at end of stop", int'(in_ready), int'(!brk_mid));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int s;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(tx === 1'b1, "R1 tx after reset", int'(tx), 1);
        check(busy === 1'b0, "R1 busy after reset", int'(busy), 0);
        check(in_ready === 1'b1, "R1 ready after reset", int'(in_ready), 1);

        for (int i = 0; i < NVEC; i++) begin
            send_frame(VECS[i], 1'b0);
        end

        // R8 break from idle, with a character offered that must be ignored
        @(negedge clk);
        cfg_factor = 7'd16; cfg_stop = 6'd24; cfg_data_bits = 4'd8; cfg_parity = 3'd0;
        break_req = 1'b1; in_valid = 1'b1; in_data = 8'h55;
        @(negedge clk);
        check(tx === 1'b0 && busy === 1'b1, "R8 break drives line low", int'(tx), 0);
        check(in_ready === 1'b0, "R8 no ready during break", int'(in_ready), 0);
        cfg_stop = 6'd3;
        repeat (20) @(negedge clk);
        check(tx === 1'b0 && busy === 1'b1, "R8 break held", int'(tx), 0);
        break_req = 1'b0; in_valid = 1'b0;
        @(posedge clk);
        check_stop_only(stop_len(16, 24), "R9 post-break");

        // R8 break requested during a frame, then released
        send_frame(VECS[1], 1'b1);
        @(negedge clk);
        check(tx === 1'b0 && busy === 1'b1, "R8 break after frame", int'(tx), 0);
        s = stop_len(int'(cfg_factor), int'(cfg_stop));
        repeat (6) @(negedge clk);
        break_req = 1'b0;
        @(posedge clk);
        check_stop_only(s, "R9 post-break whole-bit");

        // R6 idle state restored
        @(negedge clk);
        check(in_ready === 1'b1 && tx === 1'b1, "R6 idle ready", int'(in_ready), 1);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule